// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the read-lookup path of a small first-level data cache. A request brings a 32-bit virtual address and a privilege bit. The cache set is chosen from address bits that lie inside the 8 KiB page, so they are the same before and after translation. The set's tags, valid bits and the addressed data word are read in the same cycle that a small set-associative translation buffer turns the virtual page number into a physical frame number. In the following cycle the frame number is compared with the tags of all four ways in parallel. The matching way drives the data word out. When the translation is missing or not permitted, a fault flag is raised in place of a hit.

Lines are installed through a fill port that takes a physical line address and a whole line. Translations are installed through a write port that names the translation way explicitly. Page walks, stores, write-back and coherence are handled elsewhere.

A two-state controller runs the response timing. `ST_IDLE` means no response is due. `ST_RESP` means a response is on the outputs. A request in any cycle moves the controller to `ST_RESP` (IDLE→RESP or RESP→RESP). A cycle with no request moves it to `ST_IDLE` (RESP→IDLE or IDLE→IDLE).

Top module: `vipt_lookup`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one response, with `rsp_valid` high in the next cycle. Back-to-back requests give back-to-back responses. Without a request, `rsp_valid` is low in the next cycle.
- R2: Virtual address fields: bits [1:0] select a byte and do not affect the result; bits [4:2] pick one of 8 32-bit words in the line, and word k is line bits [32k+31:32k]; bits [12:5] form the set index; bits [31:13] form the virtual page number. The physical address is {frame[14:0], vaddr[12:0]}.
- R3: The translation buffer has 2 sets of 8 ways. The set is virtual page number bit 0, and `tlbw_way` selects the way written. A lookup matches only an entry whose stored valid flag is set. Writing an entry with `tlbw_entry_ok` low removes that translation.
- R4: A hit requires a valid line in the indexed set whose stored 15-bit frame equals the translated frame. A frame that differs gives a miss: `rsp_hit` is low with no fault flags.
- R5: When no translation-buffer entry matches, `rsp_tlb_miss` is high and `rsp_hit` and `rsp_perm_fault` are low.
- R6: Permission field `tlbw_perm`: bit 0 read, bit 1 write, bit 2 execute, bit 3 kernel-only. A translated access with read clear, or with kernel-only set while `req_user` is high, raises `rsp_perm_fault` and keeps `rsp_hit` low, even if the line is present.
- R7: A fill writes the line at set `fill_paddr[12:5]` with tag `fill_paddr[27:13]`. The way chosen is the lowest-numbered invalid way of that set. If all four ways are valid, the way is taken from a per-set pointer that starts at way 0 after reset and advances by one after each such replacement.
- R8: Reset clears every cache line valid bit and every translation-buffer valid flag, and holds `rsp_valid` low.
- R9: While `rsp_valid` is low, all response flags and `rsp_data` are zero. `rsp_data` is zero whenever `rsp_hit` is low.
- R10: Tags are physical. Two virtual pages mapped to the same frame hit the same cached line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual byte address |
| req_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Line hit with a permitted translation |
| rsp_data | output | 32 | Selected word on a hit, else zero |
| rsp_tlb_miss | output | 1 | No translation found |
| rsp_perm_fault | output | 1 | Translation found but access not permitted |
| fill_valid | input | 1 | Line fill strobe |
| fill_paddr | input | 28 | Physical address of the line (bits [4:0] ignored) |
| fill_line | input | 256 | Line contents, word 0 in the low bits |
| tlbw_valid | input | 1 | Translation write strobe |
| tlbw_way | input | 3 | Translation way to write |
| tlbw_vpn | input | 19 | Virtual page number of the entry |
| tlbw_pfn | input | 15 | Physical frame number of the entry |
| tlbw_entry_ok | input | 1 | Valid flag stored with the entry |
| tlbw_perm | input | 4 | Permission flags as in R6 |

## Verification
The properties assume that the same physical line is never resident in two ways of one set. They also assume that no two ways of a translation set hold the same page number, and that fills and translation writes never share a cycle with a request to the same set. The stimulus keeps to these rules. Each filled line uses a frame and index pair that is not already present. Each page number is written to only one translation way. Every fill and translation write is done in its own cycle, away from lookups. The replacement order is observed only through which of several frames sharing one set still hit.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef struct packed {
        logic kern;
        logic exec;
        logic wr;
        logic rd;
    } perm_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_t;

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
    parameter int VPN_W = 19,
    parameter int PFN_W = 15,
    parameter int SETS  = 2,
    parameter int WAYS  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(WAYS)-1:0]  wr_way,
    input  logic [VPN_W-1:0]         wr_vpn,
    input  logic [PFN_W-1:0]         wr_pfn,
    input  logic                     wr_ok,
    input  vipt_pkg::perm_t          wr_perm,
    input  logic [VPN_W-1:0]         lk_vpn,
    output logic                     lk_hit,
    output logic [PFN_W-1:0]         lk_pfn,
    output vipt_pkg::perm_t          lk_perm
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - SET_W;

    logic [WAYS-1:0]  ent_vld [SETS];
    logic [TAG_W-1:0] ent_tag [SETS][WAYS];
    logic [PFN_W-1:0] ent_pfn [SETS][WAYS];
    vipt_pkg::perm_t  ent_prm [SETS][WAYS];

    logic [SET_W-1:0] wr_set, lk_set;
    logic [TAG_W-1:0] wr_tag, lk_tag;
    logic [WAYS-1:0]  match;

    assign wr_set = wr_vpn[SET_W-1:0];
    assign wr_tag = wr_vpn[VPN_W-1:SET_W];
    assign lk_set = lk_vpn[SET_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SET_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ent_vld[s] <= '0;
        end else if (wr_en) begin
            ent_vld[wr_set][wr_way] <= wr_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_tag[wr_set][wr_way] <= wr_tag;
            ent_pfn[wr_set][wr_way] <= wr_pfn;
            ent_prm[wr_set][wr_way] <= wr_perm;
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = ent_vld[lk_set][g] && (ent_tag[lk_set][g] == lk_tag);
    end

    always_comb begin
        lk_pfn  = '0;
        lk_perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                lk_pfn  = lk_pfn | ent_pfn[lk_set][w];
                lk_perm = lk_perm | ent_prm[lk_set][w];
            end
        end
    end

    assign lk_hit = |match;

endmodule

// File: rtl/vipt_cache_array.sv
module vipt_cache_array #(
    parameter int SETS   = 256,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 15,
    parameter int LINE_W = 256,
    parameter int WORD_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 rd_en,
    input  logic [$clog2(SETS)-1:0]              rd_idx,
    input  logic [$clog2(LINE_W/WORD_W)-1:0]     rd_wsel,
    output logic [WAYS-1:0][TAG_W-1:0]           rd_tag_q,
    output logic [WAYS-1:0]                      rd_vld_q,
    output logic [WAYS-1:0][WORD_W-1:0]          rd_word_q,
    input  logic                                 fill_en,
    input  logic [$clog2(SETS)-1:0]              fill_idx,
    input  logic [TAG_W-1:0]                     fill_tag,
    input  logic [LINE_W-1:0]                    fill_line
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0]   line_vld [SETS];
    logic [WAY_W-1:0]  rr_ptr   [SETS];
    logic [TAG_W-1:0]  line_tag [SETS][WAYS];
    logic [LINE_W-1:0] line_mem [SETS][WAYS];

    logic [WAY_W-1:0] victim;
    logic             use_rr;

    always_comb begin
        victim = rr_ptr[fill_idx];
        use_rr = 1'b1;
        for (int w = WAYS-1; w >= 0; w--) begin
            if (!line_vld[fill_idx][w]) begin
                victim = WAY_W'(w);
                use_rr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                line_vld[s] <= '0;
                rr_ptr[s]   <= '0;
            end
        end else if (fill_en) begin
            line_vld[fill_idx][victim] <= 1'b1;
            if (use_rr) rr_ptr[fill_idx] <= rr_ptr[fill_idx] + WAY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            line_tag[fill_idx][victim] <= fill_tag;
            line_mem[fill_idx][victim] <= fill_line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_vld_q <= '0;
        else if (rd_en) rd_vld_q <= line_vld[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                rd_tag_q[w]  <= line_tag[rd_idx][w];
                rd_word_q[w] <= line_mem[rd_idx][w][rd_wsel*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 15,
    parameter int WORD_W = 32
) (
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [WAYS-1:0]             vlds,
    input  logic [WAYS-1:0][WORD_W-1:0] words,
    input  logic [TAG_W-1:0]            ptag,
    output logic [WAYS-1:0]             way_hit,
    output logic                        any_hit,
    output logic [WORD_W-1:0]           word
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign way_hit[g] = vlds[g] && (tags[g] == ptag);
    end

    always_comb begin
        word = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) word = word | words[w];
        end
    end

    assign any_hit = |way_hit;

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
    parameter int VA_W        = 32,
    parameter int PA_W        = 28,
    parameter int PAGE_W      = 13,
    parameter int LINE_BYTES  = 32,
    parameter int WAYS        = 4,
    parameter int CACHE_BYTES = 32768,
    parameter int WORD_W      = 32,
    parameter int TLB_SETS    = 2,
    parameter int TLB_WAYS    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [VA_W-1:0]               req_vaddr,
    input  logic                          req_user,
    output logic                          rsp_valid,
    output logic                          rsp_hit,
    output logic [WORD_W-1:0]             rsp_data,
    output logic                          rsp_tlb_miss,
    output logic                          rsp_perm_fault,
    input  logic                          fill_valid,
    input  logic [PA_W-1:0]               fill_paddr,
    input  logic [LINE_BYTES*8-1:0]       fill_line,
    input  logic                          tlbw_valid,
    input  logic [$clog2(TLB_WAYS)-1:0]   tlbw_way,
    input  logic [VA_W-PAGE_W-1:0]        tlbw_vpn,
    input  logic [PA_W-PAGE_W-1:0]        tlbw_pfn,
    input  logic                          tlbw_entry_ok,
    input  logic [3:0]                    tlbw_perm
);
    import vipt_pkg::*;

    localparam int VPN_W  = VA_W - PAGE_W;
    localparam int PFN_W  = PA_W - PAGE_W;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SETS   = CACHE_BYTES / (WAYS * LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = OFF_W - BSEL_W;

    // request-cycle fields
    logic [VPN_W-1:0]  req_vpn;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;

    assign req_vpn  = req_vaddr[VA_W-1:PAGE_W];
    assign req_idx  = req_vaddr[OFF_W +: IDX_W];
    assign req_wsel = req_vaddr[BSEL_W +: WSEL_W];

    // translation, in parallel with the set read
    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_pfn;
    perm_t            tlb_perm;

    vipt_tlb #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .SETS(TLB_SETS), .WAYS(TLB_WAYS)
    ) u_tlb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tlbw_valid),
        .wr_way  (tlbw_way),
        .wr_vpn  (tlbw_vpn),
        .wr_pfn  (tlbw_pfn),
        .wr_ok   (tlbw_entry_ok),
        .wr_perm (perm_t'(tlbw_perm)),
        .lk_vpn  (req_vpn),
        .lk_hit  (tlb_hit),
        .lk_pfn  (tlb_pfn),
        .lk_perm (tlb_perm)
    );

    logic [WAYS-1:0][PFN_W-1:0]  set_tag_q;
    logic [WAYS-1:0]             set_vld_q;
    logic [WAYS-1:0][WORD_W-1:0] set_word_q;

    vipt_cache_array #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(PFN_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (req_valid),
        .rd_idx    (req_idx),
        .rd_wsel   (req_wsel),
        .rd_tag_q  (set_tag_q),
        .rd_vld_q  (set_vld_q),
        .rd_word_q (set_word_q),
        .fill_en   (fill_valid),
        .fill_idx  (fill_paddr[OFF_W +: IDX_W]),
        .fill_tag  (fill_paddr[PA_W-1:PAGE_W]),
        .fill_line (fill_line)
    );

    // translation result held for the response cycle
    logic             tlb_hit_q;
    logic [PFN_W-1:0] pfn_q;
    perm_t            perm_q;
    logic             user_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tlb_hit_q <= 1'b0;
            pfn_q     <= '0;
            perm_q    <= '0;
            user_q    <= 1'b0;
        end else if (req_valid) begin
            tlb_hit_q <= tlb_hit;
            pfn_q     <= tlb_pfn;
            perm_q    <= tlb_perm;
            user_q    <= req_user;
        end
    end

    logic [WAYS-1:0]   way_hit;
    logic              line_hit;
    logic [WORD_W-1:0] line_word;

    vipt_way_match #(
        .WAYS(WAYS), .TAG_W(PFN_W), .WORD_W(WORD_W)
    ) u_match (
        .tags    (set_tag_q),
        .vlds    (set_vld_q),
        .words   (set_word_q),
        .ptag    (pfn_q),
        .way_hit (way_hit),
        .any_hit (line_hit),
        .word    (line_word)
    );

    logic perm_bad;
    assign perm_bad = !perm_q.rd || (perm_q.kern && user_q);

    // response controller
    state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_valid      = 1'b0;
        rsp_hit        = 1'b0;
        rsp_data       = '0;
        rsp_tlb_miss   = 1'b0;
        rsp_perm_fault = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (!tlb_hit_q) begin
                    rsp_tlb_miss = 1'b1;
                end else if (perm_bad) begin
                    rsp_perm_fault = 1'b1;
                end else if (line_hit) begin
                    rsp_hit  = 1'b1;
                    rsp_data = line_word;
                end
            end
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{req_vaddr[BSEL_W-1:0], fill_paddr[OFF_W-1:0], perm_q.wr, perm_q.exec};

endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
    parameter int WAYS   = 4,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WORD_W-1:0] rsp_data,
    input logic              rsp_tlb_miss,
    input logic              rsp_perm_fault,
    input logic [WAYS-1:0]   way_hit
);
    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R5
    tlb_miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tlb_miss |-> (!rsp_hit && !rsp_perm_fault));

    // R6
    fault_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_perm_fault |-> !rsp_hit);

    // R9
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_tlb_miss && !rsp_perm_fault && rsp_data == '0));

    // R9
    data_zero_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_data == '0);

    // R4
    single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R4
    hit_has_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> way_hit != '0);

endmodule

bind vipt_lookup vipt_lookup_chk #(.WAYS(WAYS), .WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_data       (rsp_data),
    .rsp_tlb_miss   (rsp_tlb_miss),
    .rsp_perm_fault (rsp_perm_fault),
    .way_hit        (way_hit)
);

// File: tb/sim_vipt_lookup.sv
`timescale 1ns/1ps
module sim_vipt_lookup;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_vaddr = '0;
    logic         req_user = 1'b0;
    logic         rsp_valid, rsp_hit, rsp_tlb_miss, rsp_perm_fault;
    logic [31:0]  rsp_data;
    logic         fill_valid = 1'b0;
    logic [27:0]  fill_paddr = '0;
    logic [255:0] fill_line = '0;
    logic         tlbw_valid = 1'b0;
    logic [2:0]   tlbw_way = '0;
    logic [18:0]  tlbw_vpn = '0;
    logic [14:0]  tlbw_pfn = '0;
    logic         tlbw_entry_ok = 1'b0;
    logic [3:0]   tlbw_perm = '0;

    int n_checks = 0;
    int n_err    = 0;

    // status nibble {valid, hit, tlb_miss, perm_fault}
    localparam logic [3:0] S_HIT   = 4'b1100;
    localparam logic [3:0] S_MISS  = 4'b1000;
    localparam logic [3:0] S_TLBM  = 4'b1010;
    localparam logic [3:0] S_FAULT = 4'b1001;
    localparam logic [3:0] P_RD    = 4'b0001;
    localparam logic [3:0] P_KERN  = 4'b1000;

    always #5 clk = ~clk;

    vipt_lookup u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .rsp_tlb_miss(rsp_tlb_miss), .rsp_perm_fault(rsp_perm_fault),
        .fill_valid(fill_valid), .fill_paddr(fill_paddr), .fill_line(fill_line),
        .tlbw_valid(tlbw_valid), .tlbw_way(tlbw_way), .tlbw_vpn(tlbw_vpn),
        .tlbw_pfn(tlbw_pfn), .tlbw_entry_ok(tlbw_entry_ok), .tlbw_perm(tlbw_perm)
    );

    function automatic logic [31:0] va_of(input logic [18:0] vpn, input logic [7:0] idx,
                                          input logic [2:0] wd);
        return {vpn, idx, wd, 2'b00};
    endfunction

    function automatic logic [3:0] status();
        return {rsp_valid, rsp_hit, rsp_tlb_miss, rsp_perm_fault};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tlb_write(input logic [2:0] way, input logic [18:0] vpn,
                             input logic [14:0] pfn, input logic ok, input logic [3:0] perm);
        @(negedge clk);
        tlbw_valid = 1'b1; tlbw_way = way; tlbw_vpn = vpn;
        tlbw_pfn = pfn; tlbw_entry_ok = ok; tlbw_perm = perm;
        @(negedge clk);
        tlbw_valid = 1'b0;
    endtask

    task automatic fill(input logic [14:0] pfn, input logic [7:0] idx, input logic [31:0] base);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_paddr = {pfn, idx, 5'd0};
        for (int i = 0; i < 8; i++) fill_line[i*32 +: 32] = base + 32'(i);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic [31:0] va, input logic user,
                              input logic [3:0] st, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_user = user;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " status"}, {28'd0, status()}, {28'd0, st});
        chk({tag, " data"}, rsp_data, data);
    endtask

    // probe a frame through a scratch translation (set 0, way 5)
    task automatic probe(input string tag, input logic [14:0] pfn, input logic [7:0] idx,
                         input logic [3:0] st, input logic [31:0] data);
        tlb_write(3'd5, 19'h00500, pfn, 1'b1, P_RD);
        expect_rsp(tag, va_of(19'h00500, idx, 3'd0), 1'b0, st, data);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R8 idle after reset", {28'd0, status()}, 32'd0);
        expect_rsp("R8 tlb cleared", va_of(19'h00007, 8'h00, 3'd0), 1'b0, S_TLBM, 32'd0);
        tlb_write(3'd0, 19'h00010, 15'h0010, 1'b1, P_RD);
        expect_rsp("R8 lines cleared", va_of(19'h00010, 8'h00, 3'd0), 1'b0, S_MISS, 32'd0);
        @(negedge clk);
        chk("R1 no request no response", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_basic();
        tlb_write(3'd1, 19'h12345, 15'h0ABC, 1'b1, P_RD);
        fill(15'h0ABC, 8'h21, 32'hA000_0000);
        expect_rsp("R4 hit word3", va_of(19'h12345, 8'h21, 3'd3), 1'b0, S_HIT, 32'hA000_0003);
        expect_rsp("R2 byte bits ignored", va_of(19'h12345, 8'h21, 3'd7) | 32'h3, 1'b0,
                   S_HIT, 32'hA000_0007);
        expect_rsp("R2 other index misses", va_of(19'h12345, 8'h22, 3'd0), 1'b0, S_MISS, 32'd0);
    endtask

    task automatic t_physical();
        tlb_write(3'd2, 19'h54321, 15'h0ABC, 1'b1, P_RD);
        expect_rsp("R10 alias page hits", va_of(19'h54321, 8'h21, 3'd0), 1'b0, S_HIT,
                   32'hA000_0000);
        tlb_write(3'd1, 19'h12346, 15'h0ABD, 1'b1, P_RD);
        expect_rsp("R4 frame mismatch", va_of(19'h12346, 8'h21, 3'd0), 1'b0, S_MISS, 32'd0);
    endtask

    task automatic t_tlb_sets();
        tlb_write(3'd2, 19'h00100, 15'h0200, 1'b1, P_RD);
        tlb_write(3'd3, 19'h00101, 15'h0201, 1'b1, P_RD);
        fill(15'h0200, 8'h40, 32'hB000_0000);
        fill(15'h0201, 8'h40, 32'hC000_0000);
        expect_rsp("R3 even page set", va_of(19'h00100, 8'h40, 3'd1), 1'b0, S_HIT, 32'hB000_0001);
        expect_rsp("R3 odd page set", va_of(19'h00101, 8'h40, 3'd1), 1'b0, S_HIT, 32'hC000_0001);
        expect_rsp("R5 unmapped page", va_of(19'h00102, 8'h40, 3'd0), 1'b0, S_TLBM, 32'd0);
        tlb_write(3'd2, 19'h00100, 15'h0200, 1'b0, P_RD);
        expect_rsp("R3 invalidated entry", va_of(19'h00100, 8'h40, 3'd0), 1'b0, S_TLBM, 32'd0);
    endtask

    task automatic t_perm();
        tlb_write(3'd3, 19'h00300, 15'h0300, 1'b1, 4'b0000);
        fill(15'h0300, 8'h10, 32'hE000_0000);
        expect_rsp("R6 no read flag", va_of(19'h00300, 8'h10, 3'd0), 1'b0, S_FAULT, 32'd0);
        tlb_write(3'd4, 19'h00302, 15'h0301, 1'b1, P_KERN | P_RD);
        fill(15'h0301, 8'h10, 32'hD000_0000);
        expect_rsp("R6 kernel page user", va_of(19'h00302, 8'h10, 3'd2), 1'b1, S_FAULT, 32'd0);
        expect_rsp("R6 kernel page kernel", va_of(19'h00302, 8'h10, 3'd2), 1'b0, S_HIT,
                   32'hD000_0002);
    endtask

    task automatic t_replace();
        for (int k = 0; k < 4; k++) fill(15'h0400 + 15'(k), 8'h55, 32'h4000_0000 + 32'(k << 8));
        for (int k = 0; k < 4; k++)
            probe("R7 four ways resident", 15'h0400 + 15'(k), 8'h55, S_HIT, 32'h4000_0000 + 32'(k << 8));
        fill(15'h0404, 8'h55, 32'h4000_0400);
        probe("R7 first victim way0", 15'h0400, 8'h55, S_MISS, 32'd0);
        probe("R7 new line hits", 15'h0404, 8'h55, S_HIT, 32'h4000_0400);
        probe("R7 way1 kept", 15'h0401, 8'h55, S_HIT, 32'h4000_0100);
        fill(15'h0405, 8'h55, 32'h4000_0500);
        probe("R7 second victim way1", 15'h0401, 8'h55, S_MISS, 32'd0);
        probe("R7 way2 kept", 15'h0402, 8'h55, S_HIT, 32'h4000_0200);
        fill(15'h0400, 8'h55, 32'h4000_0600);
        probe("R7 third victim way2", 15'h0402, 8'h55, S_MISS, 32'd0);
        probe("R7 refilled line", 15'h0400, 8'h55, S_HIT, 32'h4000_0600);
        probe("R7 way3 kept", 15'h0403, 8'h55, S_HIT, 32'h4000_0300);
        fill(15'h0410, 8'h56, 32'h5000_0000);
        fill(15'h0411, 8'h56, 32'h5100_0000);
        probe("R7 invalid way used first", 15'h0410, 8'h56, S_HIT, 32'h5000_0000);
        probe("R7 invalid way used second", 15'h0411, 8'h56, S_HIT, 32'h5100_0000);
    endtask

    task automatic t_pipeline();
        @(negedge clk);
        req_valid = 1'b1; req_user = 1'b0; req_vaddr = va_of(19'h12345, 8'h21, 3'd5);
        @(negedge clk);
        chk("R1 back-to-back first status", {28'd0, status()}, {28'd0, S_HIT});
        chk("R1 back-to-back first data", rsp_data, 32'hA000_0005);
        req_vaddr = va_of(19'h00101, 8'h40, 3'd6);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 back-to-back second status", {28'd0, status()}, {28'd0, S_HIT});
        chk("R1 back-to-back second data", rsp_data, 32'hC000_0006);
        @(negedge clk);
        chk("R9 quiet after burst", {rsp_data[27:0], status()}, 32'd0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_physical();
        t_tlb_sets();
        t_perm();
        t_replace();
        t_pipeline();
        report();
    end

endmodule